// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Register

This block gathers three event pulses from a real-time clock core: the periodic tick, the alarm match and the end of a time update. Each pulse is held in a sticky flag bit of the register at index 12. A control register at index 11 holds one enable bit per source. The block drives an active-high, level interrupt request whenever a set flag has its enable bit set.

Software services the interrupt by reading the flag register. The read returns the flags together with a summary bit, and it clears every flag as a side effect. A status register at index 13 always reports valid RAM and time. The event generators are outside this block. They present single-cycle pulses.

Register access is single-cycle. Read data is combinational from the address while the read strobe is high. Writes and read side effects take effect at the next rising clock edge. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `rtc_irq_flags`

## Requirements
- R1: While reset is applied, and after it is released, all flags and the control register are 0 and `irq` is 0.
- R2: A pulse on `ev_periodic`, `ev_alarm` or `ev_update` sets the matching flag at the next clock edge, whatever its enable bit holds.
- R3: A read of index 12 returns the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4, with bits 3:0 reading 0.
- R4: Bit 7 of the index 12 read data, and the `irq` output, are 1 exactly when some flag is set and its enable bit (control bit 6 periodic, bit 5 alarm, bit 4 update) is also 1.
- R5: Once set, a flag stays set until index 12 is read, so `irq` stays asserted as a level until that read.
- R6: A read of index 12 clears all three flags at the clock edge that ends the read cycle.
- R7: An event that arrives in the same cycle as a clearing read leaves its flag set after that edge.
- R8: A write to index 11 stores the whole data byte, and a read of index 11 returns it.
- R9: A read of index 13 always returns 0x80, and writes to index 13 change nothing visible.
- R10: A write to index 12 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W (7) | Register index |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data; 0 when no read is in progress or the index is unmapped |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_alarm | input | 1 | Alarm match pulse |
| ev_update | input | 1 | Update-ended pulse |
| irq | output | 1 | Level interrupt request, active high |

## Verification
Two functions can fall in one cycle: an event setting a flag and the host read that clears the flags. Directed cycles place an event on each source in the same cycle as a read of index 12. They also place a read and an event on different sources together. The flag must stay set afterwards, and the read data of that cycle must show only the older flags. A long mixed phase then drives reads, writes and events that collide freely, and a behavioural model checks `irq` and read data against the design on every clock.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_SRC   = 3;
  localparam int unsigned SRC_LSB   = 4;   // update=4, alarm=5, periodic=6
  localparam int unsigned SUM_BIT   = 7;
  localparam int unsigned IDX_CTRL  = 11;
  localparam int unsigned IDX_FLAGS = 12;
  localparam int unsigned IDX_STAT  = 13;
  localparam logic [REG_W-1:0] STAT_VALUE = 8'h80;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NUM_SRC-1:0] ev,
  output logic [NUM_SRC-1:0] flags
);
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] flag_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    // clear by read first, then set by event: a coincident event survives
    always_comb begin
      flag_d[i] = (flag_q[i] & ~clr) | ev[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> flag_q[i]);
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ev[i]) |=> !flag_q[i]);
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr) |=> flag_q[i]);
  end

  assign flags = flag_q;
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl
);
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  // R8
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q == $past(wdata));
  // R8
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/rtc_irq_summary.sv
module rtc_irq_summary #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] enables,
  output logic               pending
);
  logic [NUM_SRC-1:0] masked;

  always_comb begin
    masked  = flags & enables;
    pending = |masked;
  end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic              ev_periodic,
  input  logic              ev_alarm,
  input  logic              ev_update,
  output logic              irq
);
  localparam int unsigned SRC_MSB = SRC_LSB + NUM_SRC - 1;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(IDX_CTRL);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(IDX_FLAGS);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(IDX_STAT);

  logic               rst_sync_n;
  logic               sel_ctrl, sel_flags, sel_stat;
  logic               rd_clr;
  logic               ctrl_wr;
  logic [NUM_SRC-1:0] ev_vec;
  logic [NUM_SRC-1:0] flags;
  logic [REG_W-1:0]   ctrl;
  logic               pending;

  rtc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    sel_ctrl  = (host_addr == A_CTRL);
    sel_flags = (host_addr == A_FLAGS);
    sel_stat  = (host_addr == A_STAT);
    rd_clr    = host_rd & sel_flags;
    ctrl_wr   = host_wr & sel_ctrl;
    ev_vec    = {ev_periodic, ev_alarm, ev_update};
  end

  rtc_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (rd_clr),
    .ev    (ev_vec),
    .flags (flags)
  );

  rtc_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (ctrl_wr),
    .wdata (host_wdata),
    .ctrl  (ctrl)
  );

  rtc_irq_summary #(.NUM_SRC(NUM_SRC)) u_sum (
    .flags   (flags),
    .enables (ctrl[SRC_MSB:SRC_LSB]),
    .pending (pending)
  );

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      if (sel_flags) begin
        host_rdata[SUM_BIT]         = pending;
        host_rdata[SRC_MSB:SRC_LSB] = flags;
      end else if (sel_ctrl) begin
        host_rdata = ctrl;
      end else if (sel_stat) begin
        host_rdata = STAT_VALUE;
      end
    end
  end

  assign irq = pending;

  // R4
  sum_matches_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_clr |-> host_rdata[SUM_BIT] == irq);
  // R3
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_clr |-> host_rdata[SRC_LSB-1:0] == '0);
  // R9
  status_const_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_rd && sel_stat) |-> host_rdata == STAT_VALUE);
  // R6
  irq_drops_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_clr && ev_vec == '0) |=> !irq);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!irq && flags == '0));
endmodule

// File: tb/tb_rtc_irq_flags.sv
`timescale 1ns/1ps
module tb_rtc_irq_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] host_addr = '0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       ev_periodic = 1'b0, ev_alarm = 1'b0, ev_update = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  bit       m_per, m_alm, m_upd;
  bit [7:0] m_ctrl;

  always #5 clk = ~clk;

  rtc_irq_flags dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
    .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic bit m_sum();
    return (m_per & m_ctrl[6]) | (m_alm & m_ctrl[5]) | (m_upd & m_ctrl[4]);
  endfunction

  function automatic logic [7:0] m_read(logic rd, logic [6:0] a);
    if (!rd) return 8'h00;
    case (a)
      7'd12:   return {m_sum(), m_per, m_alm, m_upd, 4'b0000};
      7'd11:   return m_ctrl;
      7'd13:   return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  // one bus cycle: drive at negedge, compare before the edge, advance model
  task automatic step(logic rd, logic wr, logic [6:0] a, logic [7:0] wd,
                      logic ep, logic ea, logic eu, string req);
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
    ev_periodic = ep; ev_alarm = ea; ev_update = eu;
    #1;
    check({req, " rdata"}, host_rdata, m_read(rd, a));
    check("R4 irq", {7'b0, irq}, {7'b0, m_sum()});
    @(posedge clk);
    if (rd && a == 7'd12) begin m_per = 0; m_alm = 0; m_upd = 0; end
    m_per |= ep; m_alm |= ea; m_upd |= eu;
    if (wr && a == 7'd11) m_ctrl = wd;
  endtask

  task automatic idle();
    step(0, 0, 7'd0, 8'h00, 0, 0, 0, "idle");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_per = 0; m_alm = 0; m_upd = 0; m_ctrl = 0;
    // R1: while in reset, try events and a read
    repeat (2) @(negedge clk);
    host_rd = 1; host_addr = 7'd12; ev_alarm = 1; #1;
    check("R1 flags in reset", host_rdata, 8'h00);
    check("R1 irq in reset", {7'b0, irq}, 8'h00);
    @(negedge clk);
    host_rd = 0; ev_alarm = 0;
    rst_n = 1;
    repeat (4) @(negedge clk);
    step(1, 0, 7'd12, 8'h00, 0, 0, 0, "R1");
    step(1, 0, 7'd11, 8'h00, 0, 0, 0, "R1");

    // R2: flags latch with enables off, irq stays low
    step(0, 0, 7'd0, 8'h00, 1, 0, 0, "R2");
    step(0, 0, 7'd0, 8'h00, 0, 1, 0, "R2");
    step(0, 0, 7'd0, 8'h00, 0, 0, 1, "R2");
    step(1, 0, 7'd12, 8'h00, 0, 0, 0, "R2 R3 latched");  // expect 70
    step(1, 0, 7'd12, 8'h00, 0, 0, 0, "R6 cleared");     // expect 00

    // R8: control write/readback
    step(0, 1, 7'd11, 8'hA5, 0, 0, 0, "R8");
    step(1, 0, 7'd11, 8'h00, 0, 0, 0, "R8 readback");
    step(0, 1, 7'd11, 8'h20, 0, 0, 0, "R8");  // alarm enable only

    // R4: masking per source
    step(0, 0, 7'd0, 8'h00, 1, 0, 1, "R4");
    step(1, 0, 7'd12, 8'h00, 0, 0, 0, "R4 masked");  // 50, irq 0
    step(0, 0, 7'd0, 8'h00, 0, 1, 0, "R4");
    // R5: level held over idle cycles
    repeat (5) step(0, 0, 7'd0, 8'h00, 0, 0, 0, "R5");
    step(1, 0, 7'd12, 8'h00, 0, 0, 0, "R5 R3 read");  // A0
    step(0, 0, 7'd0, 8'h00, 0, 0, 0, "R6 after read");

    // R7: event coincides with clearing read, each source
    step(0, 1, 7'd11, 8'h70, 0, 0, 0, "R8");
    step(0, 0, 7'd0, 8'h00, 0, 0, 1, "R7");
    step(1, 0, 7'd12, 8'h00, 1, 0, 0, "R7 collide");  // shows old update flag
    step(1, 0, 7'd12, 8'h00, 0, 1, 0, "R7 periodic kept");
    step(1, 0, 7'd12, 8'h00, 0, 0, 1, "R7 alarm kept");
    step(1, 0, 7'd12, 8'h00, 0, 0, 0, "R7 update kept");

    // R9: status register
    step(0, 1, 7'd13, 8'h00, 0, 0, 0, "R9");
    step(1, 0, 7'd13, 8'h00, 0, 0, 0, "R9");
    step(1, 0, 7'd11, 8'h00, 0, 0, 0, "R9 ctrl untouched");

    // R10: write to flag register ignored
    step(0, 0, 7'd0, 8'h00, 0, 1, 0, "R10");
    step(0, 1, 7'd12, 8'hFF, 0, 0, 0, "R10");
    step(0, 1, 7'd12, 8'h00, 0, 0, 0, "R10");
    step(1, 0, 7'd12, 8'h00, 0, 0, 0, "R10 flags");  // A0
    step(1, 0, 7'd12, 8'h00, 0, 0, 0, "R10 cleared");

    // mixed phase against the model
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      logic [6:0] a;
      r = $urandom;
      case (r[1:0])
        2'd0: a = 7'd11;
        2'd1: a = 7'd12;
        2'd2: a = 7'd13;
        default: a = 7'd5;
      endcase
      step(r[4:2] == 3'd0, r[7:5] == 3'd0, a, r[15:8],
           r[18:16] == 3'd0, r[21:19] == 3'd0, r[24:22] == 3'd0,
           a == 7'd12 ? "R3 R6 R7 mixed" : "R8 R9 mixed");
    end
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule